// File: doc/BRIEF.md
# Dual-Channel Serial Voice Word Port

This block carries two voice channels between a serial PCM octet port and a serial ADPCM word port. Both ports run on an external bit clock that is sampled by the block's system clock. Each PCM channel (B1, B2) has its own eight-bit enable strobe. One eight-bit ADPCM window carries the B1 nibble first and the B2 nibble second, and that window may sit anywhere in the frame. The first rising bit-clock edge of each B1 strobe marks the start of a frame.

Words received in one frame are latched into holding registers when their strobe ends. At the next frame start they move into a processing stage. That stage is shown on parallel ports toward a compression core, which is only a placeholder here. At the frame start after that, the transmit shift registers load the result. Input therefore reaches output two frames later.

Each channel has its own mode. In 32 kbit/s mode the core's words pass through. In 24 kbit/s mode only the three upper bits of each nibble are significant. In bypass, the ADPCM nibbles are relayed into the upper half of the PCM octets and the upper halves of the PCM octets are relayed into the ADPCM nibbles. A clear mode sends zero words.

Top module: `dual_voice_serial_port`

## Requirements
- R1: Serial inputs are sampled on the falling bit-clock edge. `pcm_sdo`, `pcm_sdo_oe`, `adp_sdo` and `adp_sdo_oe` change only on a rising bit-clock edge.
- R2: A PCM octet is sent and received MSB first, during the first eight bit clocks of its channel strobe. `pcm_sdo_oe` is high only for those eight bits, and `pcm_sdo` is 0 whenever `pcm_sdo_oe` is low.
- R3: In the eight-bit ADPCM window, bits 7..4 carry the B1 nibble and bits 3..0 carry the B2 nibble, MSB first. `adp_sdo_oe` is high only inside the window, and `adp_sdo` is 0 when it is low.
- R4: A frame starts at the first rising bit-clock edge on which `pcm_en_b1` is high after it was low. `core_frame` pulses for exactly one clock after that edge.
- R5: Words received in frame n appear on `core_pcm_bX` and `core_adp_bX` from the start of frame n+1. In 32 kbit/s mode (mode 2'b11), frame n+2 transmits `core_dec_bX` as the PCM octet and `core_enc_bX` as the ADPCM nibble, both sampled at the start of frame n+2.
- R6: In bypass (mode 2'b01), frame n+2 transmits {ADPCM nibble of frame n, 4'b0000} as the channel's PCM octet, and the upper nibble of the channel's PCM octet of frame n as its ADPCM nibble.
- R7: In 24 kbit/s mode (mode 2'b10), the transmitted ADPCM nibble is {core_enc[3:1], 1'b0} and `core_adp_bX` shows the received nibble with bit 0 forced to 0. The PCM octet path behaves as in 32 kbit/s mode.
- R8: In clear mode (mode 2'b00), the channel transmits an all-zero PCM octet and an all-zero ADPCM nibble.
- R9: When both PCM strobes are high together, `pcm_sdo` carries the B1 octet and both channels capture the same received octet.
- R10: A strobe longer than eight bit clocks moves only its first eight bits. Extra bits are neither sent nor captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bit clock is sampled with it |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock for both ports |
| pcm_en_b1 | input | 1 | B1 PCM strobe, also the frame reference |
| pcm_en_b2 | input | 1 | B2 PCM strobe |
| adp_en | input | 1 | ADPCM window strobe |
| pcm_sdi | input | 1 | Serial PCM data in |
| adp_sdi | input | 1 | Serial ADPCM data in |
| mode_b1 | input | 2 | B1 mode: 11 32k, 10 24k, 01 bypass, 00 clear |
| mode_b2 | input | 2 | B2 mode, same coding |
| pcm_sdo | output | 1 | Serial PCM data out |
| pcm_sdo_oe | output | 1 | High while pcm_sdo drives (else high-impedance) |
| adp_sdo | output | 1 | Serial ADPCM data out |
| adp_sdo_oe | output | 1 | High while adp_sdo drives (else high-impedance) |
| core_frame | output | 1 | One-clock frame-start pulse toward the core |
| core_pcm_b1 | output | 8 | B1 octet under processing |
| core_pcm_b2 | output | 8 | B2 octet under processing |
| core_adp_b1 | output | 4 | B1 nibble under processing (masked in 24k) |
| core_adp_b2 | output | 4 | B2 nibble under processing (masked in 24k) |
| core_enc_b1 | input | 4 | Core's encoded B1 nibble |
| core_enc_b2 | input | 4 | Core's encoded B2 nibble |
| core_dec_b1 | input | 8 | Core's decoded B1 octet |
| core_dec_b2 | input | 8 | Core's decoded B2 octet |

## Verification
The bound checker watches the local properties on every clock:
- the serial outputs and their enables move only on rising bit-clock edges;
- the enables fall once the matching strobe is gone, and the data lines are low when not enabled;
- `core_frame` is a single-clock pulse that follows a B1 strobe edge;
- the core-side words change only at a frame start;
- the 24 kbit/s mask holds.

Only the bench scenarios can show the two-frame data path through each mode. These cover bypass nibble placement, the B1-first split of the ADPCM window, shared-strobe capture, and the eight-bit limit on an overlong strobe. In each of these the expected bit stream depends on words sent two frames earlier.

// File: rtl/dvsp_pkg.sv
// Package: shared mode coding and widths for the dual voice serial port.
// Assumes: two channels; mode coding is fixed at the block's pins.
package dvsp_pkg;
    localparam int N_CH = 2;
    localparam int R24_BITS = 3;

    typedef enum logic [1:0] {
        MODE_CLEAR  = 2'b00,
        MODE_BYPASS = 2'b01,
        MODE_R24    = 2'b10,
        MODE_R32    = 2'b11
    } chan_mode_e;
endpackage

// File: rtl/dvsp_bclk_edges.sv
// Module: finds rising and falling edges of the bit clock in the system clock domain.
// Assumes: bclk is synchronous to clk and each level lasts at least two clk cycles.
module dvsp_bclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    output logic rise_evt,
    output logic fall_evt
);
    logic bclk_q;

    // Purpose: remember the bit clock level of the previous system cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk;
    end

    // Purpose: flag one-cycle edge events.
    always_comb begin
        rise_evt = bclk & ~bclk_q;
        fall_evt = ~bclk & bclk_q;
    end
endmodule

// File: rtl/dvsp_strobed_shifter.sv
// Module: serial receiver and transmitter for one strobed window of BITS bits.
//         Sends MSB first on rising edges and samples on falling edges.
//         Latches the completed word into a holding register at the last bit.
// Assumes: at least one falling edge with the strobe low between windows; BITS >= 3.
module dvsp_strobed_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise_evt,
    input  logic            fall_evt,
    input  logic            strobe,
    input  logic            sdi,
    input  logic            load,
    input  logic [BITS-1:0] load_word,
    output logic            sdo,
    output logic            oe,
    output logic [BITS-1:0] rx_word
);
    localparam int CW = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);
    localparam logic [CW-1:0] FULL = CW'(BITS);

    logic [CW-1:0]   cnt;
    logic [BITS-2:0] rx_sh;
    logic [BITS-1:0] tx_word;
    logic [BITS-1:0] tx_src;

    // Purpose: a word loaded on this very edge is sent at once.
    always_comb tx_src = load ? load_word : tx_word;

    // Purpose: drive the output side on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
            sdo     <= 1'b0;
            oe      <= 1'b0;
        end else if (rise_evt) begin
            if (strobe && cnt != FULL) begin
                sdo     <= tx_src[BITS-1];
                oe      <= 1'b1;
                tx_word <= {tx_src[BITS-2:0], 1'b0};
            end else begin
                sdo     <= 1'b0;
                oe      <= 1'b0;
                tx_word <= tx_src;
            end
        end
    end

    // Purpose: sample input bits on falling edges and latch the full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rx_sh   <= '0;
            rx_word <= '0;
        end else if (fall_evt) begin
            if (!strobe) begin
                cnt <= '0;
            end else if (cnt != FULL) begin
                rx_sh <= {rx_sh[BITS-3:0], sdi};
                cnt   <= cnt + CW'(1);
                if (cnt == LAST) rx_word <= {rx_sh, sdi};
            end
        end
    end
endmodule

// File: rtl/dvsp_frame_pipe.sv
// Module: per-channel processing stage. Loads the held words at each frame start
//         and forms the next frame's transmit words from the channel mode.
// Assumes: core_enc/core_dec hold stable around frame starts; ADP_W <= PCM_W.
module dvsp_frame_pipe
    import dvsp_pkg::*;
#(
    parameter int PCM_W = 8,
    parameter int ADP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [1:0]       mode,
    input  logic [PCM_W-1:0] hold_pcm,
    input  logic [ADP_W-1:0] hold_adp,
    input  logic [ADP_W-1:0] core_enc,
    input  logic [PCM_W-1:0] core_dec,
    output logic [PCM_W-1:0] tx_pcm,
    output logic [ADP_W-1:0] tx_adp,
    output logic [PCM_W-1:0] core_pcm,
    output logic [ADP_W-1:0] core_adp
);
    localparam logic [ADP_W-1:0] R24_MASK = {ADP_W{1'b1}} << (ADP_W - R24_BITS);
    localparam int PAD_W = PCM_W - ADP_W;

    chan_mode_e       m;
    logic [PCM_W-1:0] proc_pcm;
    logic [ADP_W-1:0] proc_adp;

    always_comb m = chan_mode_e'(mode);

    // Purpose: move the held words into the processing stage once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proc_pcm <= '0;
            proc_adp <= '0;
        end else if (frame_start) begin
            proc_pcm <= hold_pcm;
            proc_adp <= hold_adp;
        end
    end

    // Purpose: show the words under processing to the core, masked in 24k mode.
    always_comb begin
        core_pcm = proc_pcm;
        core_adp = (m == MODE_R24) ? (proc_adp & R24_MASK) : proc_adp;
    end

    // Purpose: choose the transmit words per mode.
    always_comb begin
        unique case (m)
            MODE_R32: begin
                tx_pcm = core_dec;
                tx_adp = core_enc;
            end
            MODE_R24: begin
                tx_pcm = core_dec;
                tx_adp = core_enc & R24_MASK;
            end
            MODE_BYPASS: begin
                tx_pcm = {proc_adp, {PAD_W{1'b0}}};
                tx_adp = proc_pcm[PCM_W-1 -: ADP_W];
            end
            default: begin
                tx_pcm = '0;
                tx_adp = '0;
            end
        endcase
    end
endmodule

// File: rtl/dual_voice_serial_port.sv
// Module: top of the dual-channel serial PCM/ADPCM port. It has two PCM lanes,
//         one shared ADPCM window lane, frame-start detection and two channel pipes.
// Assumes: bclk is synchronous to clk; the B1 strobe is present every frame.
module dual_voice_serial_port
    import dvsp_pkg::*;
#(
    parameter int PCM_W = 8,
    parameter int ADP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             pcm_en_b1,
    input  logic             pcm_en_b2,
    input  logic             adp_en,
    input  logic             pcm_sdi,
    input  logic             adp_sdi,
    input  logic [1:0]       mode_b1,
    input  logic [1:0]       mode_b2,
    output logic             pcm_sdo,
    output logic             pcm_sdo_oe,
    output logic             adp_sdo,
    output logic             adp_sdo_oe,
    output logic             core_frame,
    output logic [PCM_W-1:0] core_pcm_b1,
    output logic [PCM_W-1:0] core_pcm_b2,
    output logic [ADP_W-1:0] core_adp_b1,
    output logic [ADP_W-1:0] core_adp_b2,
    input  logic [ADP_W-1:0] core_enc_b1,
    input  logic [ADP_W-1:0] core_enc_b2,
    input  logic [PCM_W-1:0] core_dec_b1,
    input  logic [PCM_W-1:0] core_dec_b2
);
    localparam int WIN_W = N_CH * ADP_W;

    logic rise_evt, fall_evt;
    logic en1_seen, frame_start;

    logic [N_CH-1:0]  pcm_en, lane_sdo, lane_oe;
    logic [1:0]       mode_arr   [N_CH];
    logic [PCM_W-1:0] hold_pcm   [N_CH];
    logic [ADP_W-1:0] hold_adp   [N_CH];
    logic [ADP_W-1:0] enc_arr    [N_CH];
    logic [PCM_W-1:0] dec_arr    [N_CH];
    logic [PCM_W-1:0] tx_pcm     [N_CH];
    logic [ADP_W-1:0] tx_adp     [N_CH];
    logic [PCM_W-1:0] cpcm       [N_CH];
    logic [ADP_W-1:0] cadp       [N_CH];
    logic [WIN_W-1:0] win_rx, win_tx;

    // Purpose: gather per-channel pins into arrays.
    always_comb begin
        pcm_en      = {pcm_en_b2, pcm_en_b1};
        mode_arr[0] = mode_b1;
        mode_arr[1] = mode_b2;
        enc_arr[0]  = core_enc_b1;
        enc_arr[1]  = core_enc_b2;
        dec_arr[0]  = core_dec_b1;
        dec_arr[1]  = core_dec_b2;
    end

    dvsp_bclk_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    // Purpose: record the B1 strobe level seen at each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        en1_seen <= 1'b0;
        else if (rise_evt) en1_seen <= pcm_en_b1;
    end

    always_comb frame_start = rise_evt & pcm_en_b1 & ~en1_seen;

    // Purpose: registered one-clock frame pulse toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) core_frame <= 1'b0;
        else        core_frame <= frame_start;
    end

    // Purpose: split the ADPCM window B1-first and pack the transmit window.
    always_comb begin
        hold_adp[0] = win_rx[WIN_W-1 -: ADP_W];
        hold_adp[1] = win_rx[ADP_W-1:0];
        win_tx      = {tx_adp[0], tx_adp[1]};
    end

    genvar ch;
    generate
        for (ch = 0; ch < N_CH; ch++) begin : g_chan
            dvsp_strobed_shifter #(.BITS(PCM_W)) u_pcm_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .rise_evt  (rise_evt),
                .fall_evt  (fall_evt),
                .strobe    (pcm_en[ch]),
                .sdi       (pcm_sdi),
                .load      (frame_start),
                .load_word (tx_pcm[ch]),
                .sdo       (lane_sdo[ch]),
                .oe        (lane_oe[ch]),
                .rx_word   (hold_pcm[ch])
            );

            dvsp_frame_pipe #(.PCM_W(PCM_W), .ADP_W(ADP_W)) u_pipe (
                .clk         (clk),
                .rst_n       (rst_n),
                .frame_start (frame_start),
                .mode        (mode_arr[ch]),
                .hold_pcm    (hold_pcm[ch]),
                .hold_adp    (hold_adp[ch]),
                .core_enc    (enc_arr[ch]),
                .core_dec    (dec_arr[ch]),
                .tx_pcm      (tx_pcm[ch]),
                .tx_adp      (tx_adp[ch]),
                .core_pcm    (cpcm[ch]),
                .core_adp    (cadp[ch])
            );
        end
    endgenerate

    dvsp_strobed_shifter #(.BITS(WIN_W)) u_adp_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .strobe    (adp_en),
        .sdi       (adp_sdi),
        .load      (frame_start),
        .load_word (win_tx),
        .sdo       (adp_sdo),
        .oe        (adp_sdo_oe),
        .rx_word   (win_rx)
    );

    // Purpose: merge the PCM lanes; B1 wins when both strobes overlap.
    always_comb begin
        pcm_sdo     = lane_oe[0] ? lane_sdo[0] : lane_sdo[1];
        pcm_sdo_oe  = |lane_oe;
        core_pcm_b1 = cpcm[0];
        core_pcm_b2 = cpcm[1];
        core_adp_b1 = cadp[0];
        core_adp_b2 = cadp[1];
    end
endmodule

// File: rtl/dual_voice_serial_port_sva.sv
// Module: checker for dual_voice_serial_port, bound to every instance.
// Assumes: bclk sampled by clk exactly as the design samples it.
module dual_voice_serial_port_sva #(
    parameter int PCM_W = 8,
    parameter int ADP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk,
    input logic             pcm_en_b1,
    input logic             pcm_en_b2,
    input logic             adp_en,
    input logic [1:0]       mode_b1,
    input logic [1:0]       mode_b2,
    input logic             pcm_sdo,
    input logic             pcm_sdo_oe,
    input logic             adp_sdo,
    input logic             adp_sdo_oe,
    input logic             core_frame,
    input logic [PCM_W-1:0] core_pcm_b1,
    input logic [PCM_W-1:0] core_pcm_b2,
    input logic [ADP_W-1:0] core_adp_b1,
    input logic [ADP_W-1:0] core_adp_b2
);
    logic bclk_c, armed, rise_c;

    // Purpose: checker-side bit clock history and a post-reset flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_c <= 1'b0;
            armed  <= 1'b0;
        end else begin
            bclk_c <= bclk;
            armed  <= 1'b1;
        end
    end

    always_comb rise_c = bclk & ~bclk_c;

    AST_OUT_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !rise_c |=> $stable({pcm_sdo, pcm_sdo_oe, adp_sdo, adp_sdo_oe})); // R1
    AST_PCM_QUIET_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_c && !pcm_en_b1 && !pcm_en_b2 |=> !pcm_sdo_oe); // R2
    AST_PCM_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_sdo_oe |-> !pcm_sdo); // R2
    AST_ADP_QUIET_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rise_c && !adp_en |=> !adp_sdo_oe); // R3
    AST_ADP_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adp_sdo_oe |-> !adp_sdo); // R3
    AST_FRAME_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        core_frame |=> !core_frame); // R4
    AST_FRAME_FOLLOWS_B1: assert property (@(posedge clk) disable iff (!rst_n)
        armed && core_frame |-> $past(rise_c && pcm_en_b1)); // R4
    AST_CORE_PCM_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$stable({core_pcm_b1, core_pcm_b2}) |-> core_frame); // R5
    AST_CORE_ADP_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$stable({core_adp_b1, core_adp_b2}) && $stable({mode_b1, mode_b2}) |-> core_frame); // R5
    AST_R24_MASK_B1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_b1 == 2'b10 |-> !core_adp_b1[0]); // R7
    AST_R24_MASK_B2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_b2 == 2'b10 |-> !core_adp_b2[0]); // R7
endmodule

bind dual_voice_serial_port dual_voice_serial_port_sva #(.PCM_W(PCM_W), .ADP_W(ADP_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk        (bclk),
    .pcm_en_b1   (pcm_en_b1),
    .pcm_en_b2   (pcm_en_b2),
    .adp_en      (adp_en),
    .mode_b1     (mode_b1),
    .mode_b2     (mode_b2),
    .pcm_sdo     (pcm_sdo),
    .pcm_sdo_oe  (pcm_sdo_oe),
    .adp_sdo     (adp_sdo),
    .adp_sdo_oe  (adp_sdo_oe),
    .core_frame  (core_frame),
    .core_pcm_b1 (core_pcm_b1),
    .core_pcm_b2 (core_pcm_b2),
    .core_adp_b1 (core_adp_b1),
    .core_adp_b2 (core_adp_b2)
);

// File: tb/dual_voice_serial_port_bench.sv
// Bench: behavioural frame model with per-frame word arrays, compared on every clock.
module dual_voice_serial_port_bench;
    localparam int NF = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, pcm_en_b1 = 1'b0, pcm_en_b2 = 1'b0, adp_en = 1'b0;
    logic pcm_sdi = 1'b0, adp_sdi = 1'b0;
    logic [1:0] mode_b1 = 2'b11, mode_b2 = 2'b11;
    logic pcm_sdo, pcm_sdo_oe, adp_sdo, adp_sdo_oe, core_frame;
    logic [7:0] core_pcm_b1, core_pcm_b2, core_dec_b1 = '0, core_dec_b2 = '0;
    logic [3:0] core_adp_b1, core_adp_b2, core_enc_b1 = '0, core_enc_b2 = '0;

    always #2.5 clk = ~clk;

    dual_voice_serial_port u_dual_voice_serial_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk),
        .pcm_en_b1(pcm_en_b1), .pcm_en_b2(pcm_en_b2), .adp_en(adp_en),
        .pcm_sdi(pcm_sdi), .adp_sdi(adp_sdi), .mode_b1(mode_b1), .mode_b2(mode_b2),
        .pcm_sdo(pcm_sdo), .pcm_sdo_oe(pcm_sdo_oe), .adp_sdo(adp_sdo), .adp_sdo_oe(adp_sdo_oe),
        .core_frame(core_frame), .core_pcm_b1(core_pcm_b1), .core_pcm_b2(core_pcm_b2),
        .core_adp_b1(core_adp_b1), .core_adp_b2(core_adp_b2),
        .core_enc_b1(core_enc_b1), .core_enc_b2(core_enc_b2),
        .core_dec_b1(core_dec_b1), .core_dec_b2(core_dec_b2)
    );

    int checks = 0, fails = 0;
    int pcm1 [NF], pcm2 [NF], adp [NF], m1 [NF], m2 [NF], lay [NF];
    int enc1 [NF], enc2 [NF], dec1 [NF], dec2 [NF];
    logic chk_en = 1'b0;
    string cur_req = "R5";
    logic e_pcm_oe = 0, e_pcm_sdo = 0, e_adp_oe = 0, e_adp_sdo = 0, e_frame = 0;
    logic [7:0] e_cpcm1 = 0, e_cpcm2 = 0;
    logic [3:0] e_cadp1 = 0, e_cadp2 = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Layout 0 normal, 1 shared strobe (R9), 2 long B1 strobe (R10).
    function automatic int rx2_of(int f);
        return (lay[f] == 1) ? pcm1[f] : pcm2[f];
    endfunction
    function automatic int src_pcm(int k, int f);
        if (f < 0) return 0;
        return (k == 0) ? pcm1[f] : rx2_of(f);
    endfunction
    function automatic int src_adp(int k, int f);
        if (f < 0) return 0;
        return (k == 0) ? (adp[f] >> 4) & 15 : adp[f] & 15;
    endfunction
    function automatic int mode_of(int k, int f);
        return (k == 0) ? m1[f] : m2[f];
    endfunction
    function automatic int exp_tp(int k, int f);
        case (mode_of(k, f))
            3, 2:    return (k == 0) ? dec1[f] : dec2[f];
            1:       return (src_adp(k, f - 2) << 4);
            default: return 0;
        endcase
    endfunction
    function automatic int exp_ta(int k, int f);
        int e = (k == 0) ? enc1[f] : enc2[f];
        case (mode_of(k, f))
            3:       return e;
            2:       return e & 14;
            1:       return (src_pcm(k, f - 2) >> 4) & 15;
            default: return 0;
        endcase
    endfunction
    function automatic int masked(int k, int f, int nib);
        return (mode_of(k, f) == 2) ? (nib & 14) : nib;
    endfunction

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (chk_en) begin
            check("R2", pcm_sdo_oe, e_pcm_oe);
            check("R3", adp_sdo_oe, e_adp_oe);
            check(bclk ? cur_req : "R1", pcm_sdo, e_pcm_sdo);
            check(bclk ? cur_req : "R1", adp_sdo, e_adp_sdo);
            check("R4", core_frame, e_frame);
            check("R5", core_pcm_b1, e_cpcm1);
            check(cur_req, core_pcm_b2, e_cpcm2);
            check(cur_req, core_adp_b1, e_cadp1);
            check("R5", core_adp_b2, e_cadp2);
        end
    end

    task automatic run_frame(int f);
        int s1, l1, s2, sa;
        int tp1, tp2, tw;
        s1 = 0; l1 = 8; s2 = 8; sa = 16;
        if (lay[f] == 1) begin s2 = 0; end
        if (lay[f] == 2) begin l1 = 10; s2 = 10; sa = 18; end
        @(posedge clk); #1;
        mode_b1 = 2'(m1[f]); mode_b2 = 2'(m2[f]);
        core_enc_b1 = 4'(enc1[f]); core_enc_b2 = 4'(enc2[f]);
        core_dec_b1 = 8'(dec1[f]); core_dec_b2 = 8'(dec2[f]);
        e_cadp1 = 4'(masked(0, f, src_adp(0, f - 2)));
        e_cadp2 = 4'(masked(1, f, src_adp(1, f - 2)));
        tp1 = exp_tp(0, f); tp2 = exp_tp(1, f);
        tw = (exp_ta(0, f) << 4) | exp_ta(1, f);
        for (int b = 0; b < 32; b++) begin
            bit in1, in2, ina;
            int i1, i2, ia;
            i1 = b - s1; i2 = b - s2; ia = b - sa;
            in1 = (i1 >= 0 && i1 < l1); in2 = (i2 >= 0 && i2 < 8); ina = (ia >= 0 && ia < 8);
            @(negedge clk);
            pcm_en_b1 = in1; pcm_en_b2 = in2; adp_en = ina;
            if (in1) pcm_sdi = (i1 < 8) ? 1'((pcm1[f] >> (7 - i1)) & 1) : 1'b1;
            else if (in2) pcm_sdi = 1'((pcm2[f] >> (7 - i2)) & 1);
            else pcm_sdi = 1'b0;
            adp_sdi = ina ? 1'((adp[f] >> (7 - ia)) & 1) : 1'b0;
            @(negedge clk);
            bclk = 1'b1;
            @(posedge clk); #1;
            if (in1 && i1 < 8) begin
                e_pcm_oe = 1; e_pcm_sdo = 1'((tp1 >> (7 - i1)) & 1);
            end else if (in2) begin
                e_pcm_oe = 1; e_pcm_sdo = 1'((tp2 >> (7 - i2)) & 1);
            end else begin
                e_pcm_oe = 0; e_pcm_sdo = 0;
            end
            e_adp_oe = ina; e_adp_sdo = ina ? 1'((tw >> (7 - ia)) & 1) : 1'b0;
            if (b == 0) begin
                e_frame = 1;
                e_cpcm1 = 8'(src_pcm(0, f - 1)); e_cpcm2 = 8'(src_pcm(1, f - 1));
                e_cadp1 = 4'(masked(0, f, src_adp(0, f - 1)));
                e_cadp2 = 4'(masked(1, f, src_adp(1, f - 1)));
            end
            @(posedge clk); #1;
            e_frame = 0;
            @(negedge clk);
            @(negedge clk);
            bclk = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int f = 0; f < NF; f++) begin
            pcm1[f] = (f * 37 + 11) % 256; pcm2[f] = (f * 91 + 200) % 256;
            adp[f]  = (f * 53 + 7) % 256;
            enc1[f] = (f * 5 + 3) % 16;    enc2[f] = (f * 7 + 9) % 16;
            dec1[f] = (f * 29 + 64) % 256; dec2[f] = (f * 43 + 129) % 256;
            lay[f] = 0; m1[f] = 3; m2[f] = 3;
            if (f >= 6 && f <= 10)  begin m1[f] = 1; m2[f] = 1; end
            if (f >= 11 && f <= 14) begin m1[f] = 2; m2[f] = 3; end
            if (f >= 15 && f <= 17) begin m1[f] = 0; m2[f] = 1; end
            if (f >= 18 && f <= 20) begin m1[f] = 1; m2[f] = 1; lay[f] = 1; end
            if (f >= 21) lay[f] = 2;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", pcm_sdo_oe, 0);
        check("R3", adp_sdo_oe, 0);
        check("R4", core_frame, 0);
        check("R5", core_pcm_b1, 0);
        chk_en = 1'b1;
        for (int f = 0; f < NF; f++) begin
            if (f < 6) cur_req = "R5";
            else if (f < 11) cur_req = "R6";
            else if (f < 15) cur_req = "R7";
            else if (f < 18) cur_req = "R8";
            else if (f < 21) cur_req = "R9";
            else cur_req = "R10";
            run_frame(f);
        end
        chk_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule